// File: doc/BRIEF.md
# MDIO Management Master

This block runs serial management frames toward Ethernet PHYs on behalf of a host. The host programs four 32-bit registers through a plain register port: a configuration word, a target address, a 16-bit data word, and an operation word. Writing the operation word starts one frame. The block derives MDC from the core clock and shifts the frame out on MDIO, in either the classic framing (start `01`) or the extended framing (start `00`). Extended-framing accesses are indirect: software first runs an address cycle that carries the target register number in the data word, then a write or a read.

Bit 31 of the operation word reads as busy while a frame is on the wire, and software polls it. After a read frame the sampled 16-bit value appears in the data word. The register port is control, not a data stream: writes take effect on the clock edge where `reg_wr` is high, reads are combinational from `reg_sel`, and there is no back-pressure. An operation write that arrives while busy is dropped.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register reads zero, busy is 0, MDC is low and the MDIO output enable is low.
- R2: Register index 0 is the configuration word (bits [4+DIV_W:0] are stored), index 1 is the address word (bits [9:0]), and index 2 is the data word (bits [15:0]). Each reads back what was written, with the upper bits zero. Index 3 reads busy in bit 31 and the last launched opcode in bits [1:0].
- R3: Writing index 3 while idle launches a frame and sets busy on that clock edge. Busy stays set for exactly 2*N*(div+1) core cycles, where N is 64 with the preamble and 32 without it.
- R4: MDC stays low while idle. During a frame it is high for div+1 cycles of every bit, where div is configuration bits [5+DIV_W-1:5].
- R5: When configuration bit 2 is set, 32 one-bits go out before the start field.
- R6: In classic framing (configuration bit 3 clear) the frame is `01`, then opfield `01` for opcodes 0 and 1 or `10` for opcodes 2 and 3, then the PHY address (address bits [9:5]), then the register number (address bits [4:0]), then turnaround `10` on writes, then data bits [15:0]. Every field is sent MSB first.
- R7: In extended framing (configuration bit 3 set) the start field is `00`, and opcodes 0, 1, 2 and 3 put the opfield `00`, `01`, `11` and `10` on the wire.
- R8: For opcodes 2 and 3 the output enable drops from the first turnaround bit to the end of the frame. The 16 data bits are sampled at the rising MDC edges and land in data bits [15:0] when the frame ends.
- R9: A sampled bit is MDIO XOR configuration bit 1 when configuration bit 0 is set. It is a constant 1 when configuration bit 0 is clear.
- R10: A write to index 3 while busy is ignored. The opcode readback and the frame on the wire are unchanged.
- R11: MDIO and its output enable change only at falling MDC edges and hold steady while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register index for writes and reads |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_out |
| mdio_in | input | 1 | Serial data from the PHY |

## Verification
A wrong bit counter or frame snapshot shows on the wire within one frame: either as a misplaced field among the sampled MDIO bits, or as a busy time that misses 2*N*(div+1) by at least one bit period. A wrong divider state shows in the MDC high time within the first bit. A read shift register that drops or repeats a bit shows in the data word as soon as busy clears. A stray launch while busy shows as an opcode readback change on the next cycle.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int unsigned FRAME_BITS = 32;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned HDR_BITS   = 14;  // start + op + phy + reg
  localparam int unsigned DATA_BITS  = 16;

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_OP   = 2'd3;

  typedef enum logic [1:0] {
    OPC_ADDR   = 2'd0,
    OPC_WRITE  = 2'd1,
    OPC_READ   = 2'd2,
    OPC_RDPOST = 2'd3
  } opc_e;

  function automatic logic [1:0] start_field(input logic ext);
    return ext ? 2'b00 : 2'b01;
  endfunction

  function automatic logic [1:0] op_field(input logic ext, input logic [1:0] opc);
    if (!ext) return opc[1] ? 2'b10 : 2'b01;
    case (opc)
      OPC_ADDR:  return 2'b00;
      OPC_WRITE: return 2'b01;
      OPC_READ:  return 2'b11;
      default:   return 2'b10;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap = run && (cnt_q == div);
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;
  assign mdc  = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  pre_in,
  input  logic                  read_in,
  input  logic                  mdi_en,
  input  logic                  mdi_inv,
  input  logic                  mdio_in,
  input  logic                  rise,
  input  logic                  fall,
  output logic                  active,
  output logic                  rd_frame,
  output logic                  done,
  output logic [DATA_BITS-1:0]  capture,
  output logic                  mdio_out,
  output logic                  mdio_oe
);
  localparam int IDX_W = $clog2(PRE_BITS + FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRE_BITS + FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] BODY_IDX = IDX_W'(PRE_BITS);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + HDR_BITS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_BITS + HDR_BITS + 2);

  logic [FRAME_BITS-1:0] frame_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  active_q, rd_q;
  logic [DATA_BITS-1:0]  cap_q;
  logic                  bit_now, released, sample;
  logic [4:0]            body_pos;

  // indices below BODY_IDX are preamble ones; above it the frame goes MSB first
  assign body_pos = ~idx_q[4:0];
  assign bit_now  = (idx_q >= BODY_IDX) ? frame_q[body_pos] : 1'b1;
  assign released = rd_q && (idx_q >= TA_IDX);
  assign mdio_oe  = active_q && !released;
  assign mdio_out = mdio_oe ? bit_now : 1'b1;
  assign sample   = mdi_en ? (mdio_in ^ mdi_inv) : 1'b1;
  assign done     = fall && active_q && (idx_q == LAST_IDX);
  assign active   = active_q;
  assign rd_frame = rd_q;
  assign capture  = cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q  <= '0;
      idx_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      cap_q    <= '0;
    end else if (launch) begin
      frame_q  <= frame_in;
      idx_q    <= pre_in ? '0 : BODY_IDX;
      active_q <= 1'b1;
      rd_q     <= read_in;
      cap_q    <= '0;
    end else if (active_q) begin
      if (rise && rd_q && (idx_q >= DAT_IDX))
        cap_q <= {cap_q[DATA_BITS-2:0], sample};
      if (fall) begin
        if (idx_q == LAST_IDX) active_q <= 1'b0;
        else                   idx_q    <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_sel,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic                 rd_frame,
  input  logic [DATA_BITS-1:0] capture,
  output logic [31:0]          reg_rdata,
  output logic                 launch,
  output logic [1:0]           op_code,
  output logic                 mdi_en,
  output logic                 mdi_inv,
  output logic                 pre_en,
  output logic                 ext_frame,
  output logic [DIV_W-1:0]     div_run,
  output logic [9:0]           addr_q,
  output logic [DATA_BITS-1:0] data_q
);
  localparam int CFG_W = 5 + DIV_W;

  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       op_q;

  assign launch    = reg_wr && (reg_sel == SEL_OP) && !busy;
  assign mdi_en    = cfg_q[0];
  assign mdi_inv   = cfg_q[1];
  assign pre_en    = cfg_q[2];
  assign ext_frame = cfg_q[3];
  assign op_code   = op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      op_q    <= '0;
      div_run <= '0;
    end else begin
      if (reg_wr && reg_sel == SEL_CFG)  cfg_q  <= reg_wdata[CFG_W-1:0];
      if (reg_wr && reg_sel == SEL_ADDR) addr_q <= reg_wdata[9:0];
      if (done && rd_frame)
        data_q <= capture;
      else if (reg_wr && reg_sel == SEL_DATA)
        data_q <= reg_wdata[DATA_BITS-1:0];
      if (launch) begin
        op_q    <= reg_wdata[1:0];
        div_run <= cfg_q[5 +: DIV_W];
      end
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CFG:  reg_rdata = 32'(cfg_q);
      SEL_ADDR: reg_rdata = 32'(addr_q);
      SEL_DATA: reg_rdata = 32'(data_q);
      default:  reg_rdata = {busy, 29'b0, op_q};
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic                  busy, done, rd_frame, launch;
  logic                  mdi_en, mdi_inv, pre_en, ext_frame;
  logic                  rise, fall;
  logic [1:0]            op_code, new_opc;
  logic [DIV_W-1:0]      div_run;
  logic [9:0]            addr_q;
  logic [DATA_BITS-1:0]  data_q, capture;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  new_read;

  assign new_opc  = reg_wdata[1:0];
  assign new_read = new_opc[1];
  assign frame_word = {start_field(ext_frame), op_field(ext_frame, new_opc),
                       addr_q[9:5], addr_q[4:0],
                       new_read ? 2'b11 : 2'b10, data_q};

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .busy(busy), .done(done), .rd_frame(rd_frame),
    .capture(capture), .reg_rdata(reg_rdata), .launch(launch),
    .op_code(op_code), .mdi_en(mdi_en), .mdi_inv(mdi_inv), .pre_en(pre_en),
    .ext_frame(ext_frame), .div_run(div_run), .addr_q(addr_q), .data_q(data_q)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_run),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .launch(launch), .frame_in(frame_word),
    .pre_in(pre_en), .read_in(new_read), .mdi_en(mdi_en), .mdi_inv(mdi_inv),
    .mdio_in(mdio_in), .rise(rise), .fall(fall), .active(busy),
    .rd_frame(rd_frame), .done(done), .capture(capture),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       reg_wr,
  input logic       busy,
  input logic [1:0] op_code,
  input logic       mdc,
  input logic       mdio_out,
  input logic       mdio_oe
);
  a_r4_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && !busy) |=> busy);

  a_r10_busy_op_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && busy) |=> $stable(op_code));

  a_r11_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .busy(busy), .op_code(op_code), .mdc(mdc),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // responder / monitor shared settings (written only by the stimulus)
  int          start_id = 0;
  logic [15:0] rsp_val = '0;
  int          rsp_base = 0;
  logic        rsp_read = 1'b0;

  // monitor state (written only by the monitors)
  int          rise_id = -1;
  int          fall_id = -1;
  int          nrise = 0;
  int          nfall = 0;
  logic [63:0] obs_bits = '0;
  logic [63:0] obs_oe = '0;

  always #4 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always @(posedge mdc) begin
    if (rise_id != start_id) begin
      rise_id = start_id; nrise = 0; obs_bits = '0; obs_oe = '0;
    end
    obs_bits = {obs_bits[62:0], mdio_out};
    obs_oe   = {obs_oe[62:0], mdio_oe};
    nrise++;
  end

  always @(negedge mdc) begin
    if (fall_id != start_id) begin
      fall_id = start_id; nfall = 0;
    end
    nfall++;
    if (rsp_read && (nfall - rsp_base) >= 16 && (nfall - rsp_base) <= 31)
      mdio_in = rsp_val[15 - (nfall - rsp_base - 16)];
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic run_frame(input bit ext, input logic [1:0] op, input bit pre,
                           input int div, input bit en, input bit inv,
                           input logic [4:0] phy, input logic [4:0] rn,
                           input logic [15:0] dat, input logic [15:0] rv,
                           input bit poke);
    int n, busy_cyc, hi_cyc;
    logic [31:0] body, oe_body, rb;
    logic [63:0] exp_bits, exp_oe, msk;
    logic [1:0]  st, opf;
    logic [15:0] exp_rd;
    bit          is_rd;
    is_rd = op[1];
    wr(2'd0, (32'(div) << 5) | (32'(ext) << 3) | (32'(pre) << 2) |
             (32'(inv) << 1) | 32'(en));
    wr(2'd1, {22'b0, phy, rn});
    wr(2'd2, {16'b0, dat});
    rsp_val = rv; rsp_base = pre ? 32 : 0; rsp_read = is_rd;
    start_id++;
    @(negedge clk);
    reg_sel = 2'd3; reg_wr = 1'b1; reg_wdata = {30'b0, op};
    @(negedge clk);
    reg_wr = 1'b0;
    busy_cyc = 0; hi_cyc = 0;
    while (reg_rdata[31] && busy_cyc < 4000) begin
      busy_cyc++;
      if (mdc) hi_cyc++;
      if (poke && busy_cyc == 10) begin
        reg_wr = 1'b1; reg_wdata = {30'b0, op + 2'd1};
      end else reg_wr = 1'b0;
      if (poke && busy_cyc == 12)
        chk(reg_rdata[1:0] == op && reg_rdata[31], "R10 opcode kept while busy",
            64'(reg_rdata), 64'({1'b1, 29'b0, op}));
      @(negedge clk);
    end
    reg_wr = 1'b0;
    n = pre ? 64 : 32;
    // R3: busy duration
    chk(busy_cyc == 2 * n * (div + 1), "R3 busy cycles", 64'(busy_cyc),
        64'(2 * n * (div + 1)));
    // R4: MDC high time
    chk(hi_cyc == n * (div + 1), "R4 mdc high cycles", 64'(hi_cyc),
        64'(n * (div + 1)));
    // expected frame (R5 R6 R7)
    st  = ext ? 2'b00 : 2'b01;
    if (!ext) opf = is_rd ? 2'b10 : 2'b01;
    else opf = (op == 2'd0) ? 2'b00 : (op == 2'd1) ? 2'b01 :
               (op == 2'd2) ? 2'b11 : 2'b10;
    body    = {st, opf, phy, rn, 2'b10, dat};
    oe_body = is_rd ? 32'hFFFC_0000 : 32'hFFFF_FFFF;
    exp_bits = pre ? {32'hFFFF_FFFF, body} : {32'h0, body};
    exp_oe   = pre ? {32'hFFFF_FFFF, oe_body} : {32'h0, oe_body};
    msk      = pre ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    chk(nrise == n, "R5 bit count", 64'(nrise), 64'(n));
    chk(((obs_bits & exp_oe) & msk) == (exp_bits & exp_oe),
        ext ? "R7 extended frame bits" : "R6 classic frame bits",
        obs_bits & exp_oe & msk, exp_bits & exp_oe);
    chk((obs_oe & msk) == exp_oe, "R8 output enable pattern", obs_oe & msk, exp_oe);
    rd(2'd2, rb);
    if (is_rd) begin
      exp_rd = !en ? 16'hFFFF : (inv ? ~rv : rv);
      chk(rb == {16'b0, exp_rd}, "R8 R9 captured read data", 64'(rb), 64'(exp_rd));
    end else begin
      chk(rb == {16'b0, dat}, "R2 data kept after write", 64'(rb), 64'(dat));
    end
    rd(2'd3, rb);
    chk(rb == {30'b0, op}, "R2 op readback idle", 64'(rb), 64'(op));
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] rb;
    int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 mdc/oe after reset",
        64'({mdc, mdio_oe}), 64'(0));
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), rb);
      chk(rb == 32'h0, "R1 register zero after reset", 64'(rb), 64'(0));
    end
    // R2 readback
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, rb);
    chk(rb == 32'h0000_1FFF, "R2 cfg readback", 64'(rb), 64'h1FFF);
    wr(2'd1, 32'hFFFF_F2A5);
    rd(2'd1, rb);
    chk(rb == 32'h0000_02A5, "R2 addr readback", 64'(rb), 64'h2A5);
    wr(2'd2, 32'h1234_BEEF);
    rd(2'd2, rb);
    chk(rb == 32'h0000_BEEF, "R2 data readback", 64'(rb), 64'hBEEF);
    // sweep
    k = 0;
    for (int ext = 0; ext < 2; ext++)
      for (int op = 0; op < 4; op++)
        for (int pre = 0; pre < 2; pre++)
          for (int dv = 0; dv < 3; dv++) begin
            run_frame(ext[0], op[1:0], pre[0], (dv == 2) ? 3 : dv,
                      (k % 3) != 0, k[0], 5'(k * 7 + 3), 5'(k * 11 + 1),
                      16'(k * 16'h1357 + 16'hA5C3), 16'(k * 16'h2F1D + 16'h6B09),
                      1'b0);
            k++;
          end
    // R10 busy write ignored, classic read and extended write
    run_frame(1'b0, 2'd2, 1'b0, 1, 1'b1, 1'b0, 5'h11, 5'h0A, 16'h0F0F, 16'hC3A5, 1'b1);
    run_frame(1'b1, 2'd1, 1'b1, 0, 1'b1, 1'b0, 5'h1F, 5'h00, 16'h8001, 16'h0000, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule